// File: doc/BRIEF.md
# Serial Flash Burst Sequencer

This block sits between a request source and a serial flash shift engine. It takes one logical command (an opcode, a 24-bit start address and two byte counts, one for bytes sent and one for bytes returned) and breaks it into short engine frames. Each frame carries an opcode, an optional 3-byte address and at most four data bytes in one direction. Array reads and page programs are cut into pieces of up to four bytes, and the address moves forward by the size of each piece.

Each program piece is preceded by a write-enable frame. After it, status-read frames are sent until the device reports that its internal write has finished. A fast-read request is sent as a plain read: its dummy byte is taken from the write stream and thrown away. Write data comes in on a valid/ready byte stream, and returned bytes leave on another. Completion is a single-cycle `done` pulse with a 2-bit result code.

Top module: `flash_burst_seq`

## Requirements
- R1: A read (0x03) or program (0x02) request of L bytes produces data frames of min(remaining, 4) bytes each. The frame address starts at the request address and advances by each frame's size, modulo 2^24. Data frames of these commands have `frm_alen` = 3.
- R2: Every program data frame comes directly after a write-enable frame with opcode 0x06 and `frm_alen`, `frm_wlen` and `frm_rlen` all 0.
- R3: After every program data frame, status frames with opcode 0x05, `frm_rlen` = 1 and `frm_alen` = `frm_wlen` = 0 are repeated while bit 0 of the returned status byte (`eng_rdata[0]`) is 1. The next piece starts, or the request completes, only after a status byte with bit 0 = 0.
- R4: If POLL_MAX status frames in a row for one piece all return bit 0 = 1, the request completes with `done_err` = 3 and no further frame is issued.
- R5: Single-frame commands have fixed shapes, given as (alen, wlen, rlen): 0x06, 0x04 and 0xC7 are (0,0,0); 0x9F is (0,0,3); 0x05 is (0,0,1); 0x01 is (0,1,0), taking one byte from the write stream; 0xAB is (3,0,1); 0xD8 is (3,0,0). The request lengths are not used for these commands.
- R6: A fast-read request (0x0B) with a nonzero read length consumes one byte from the write stream and discards it. It is then handled exactly as a 0x03 read of the same address and length.
- R7: An opcode outside the listed set completes with `done_err` = 1. A request with both `req_wlen` and `req_rlen` nonzero completes with `done_err` = 2. In both cases no frame is issued and no write-stream byte is consumed.
- R8: Returned bytes leave on the read stream in arrival order. Byte i of a frame is `eng_rdata[8i+7:8i]`.
- R9: Write-stream bytes are packed into `frm_wdata`, with the i-th byte of a piece in bits [8i+7:8i] and the unused upper bytes at 0.
- R10: `done` is high for exactly one cycle, and the block is ready for a new request in the next cycle. `req_ready` is high only while idle. A read or program request with length 0 completes with `done_err` = 0 and issues no frame.
- R11: After reset, `req_ready` = 1 and `frm_valid`, `rd_valid`, `wr_ready` and `done` are all 0.
- R12: While `frm_valid` is high and `frm_ready` is low, all frame fields stay stable. While `rd_valid` is high and `rd_ready` is low, `rd_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, accepts a request |
| req_opcode | input | 8 | Command opcode |
| req_addr | input | 24 | Start address |
| req_wlen | input | LEN_W | Bytes to send from the write stream |
| req_rlen | input | LEN_W | Bytes to return on the read stream |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 2 | 0 ok, 1 unknown opcode, 2 mixed direction, 3 status-poll timeout |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Returned byte offered |
| rd_ready | input | 1 | Returned byte taken |
| rd_data | output | 8 | Returned byte |
| frm_valid | output | 1 | Frame offered to the engine |
| frm_ready | input | 1 | Engine takes the frame |
| frm_opcode | output | 8 | Frame opcode |
| frm_addr | output | 24 | Frame address |
| frm_alen | output | 2 | Address bytes in the frame (0 or 3) |
| frm_wlen | output | 3 | Data bytes sent |
| frm_rlen | output | 3 | Data bytes received |
| frm_wdata | output | 32 | Data to send, first byte in bits 7:0 |
| eng_done | input | 1 | Engine finished the frame |
| eng_rdata | input | 32 | Received bytes, first byte in bits 7:0 |

## Verification
Reads are tried with a length that is not a multiple of four, starting two bytes below the top of the address space. This separates correct piece sizing and address wrap from off-by-one piece lengths. Programs are run with a few busy polls and with more than the poll limit, which separates the retry loop from the timeout exit. Every fixed-shape opcode, a fast read, an unknown opcode, a mixed-direction request and zero-length requests each get their own run. These runs tell rewriting apart from rejection, and rejection apart from early completion. Random reads, programs and fast reads with random lengths, busy counts and stream stalls then stress ordering and backpressure.

// File: rtl/flash_burst_seq.sv
module flash_burst_seq #(
  parameter int LEN_W    = 12,
  parameter int POLL_MAX = 1024,
  localparam int PW      = $clog2(POLL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_opcode,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_wlen,
  input  logic [LEN_W-1:0] req_rlen,
  output logic             done,
  output logic [1:0]       done_err,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             frm_valid,
  input  logic             frm_ready,
  output logic [7:0]       frm_opcode,
  output logic [23:0]      frm_addr,
  output logic [1:0]       frm_alen,
  output logic [2:0]       frm_wlen,
  output logic [2:0]       frm_rlen,
  output logic [31:0]      frm_wdata,
  input  logic             eng_done,
  input  logic [31:0]      eng_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_DUMMY, S_NEXT, S_GATHER, S_WREN, S_WREN_W,
    S_CMD, S_CMD_W, S_EMIT, S_POLL, S_POLL_W, S_DONE
  } st_t;

  st_t              st;
  logic [7:0]       op;
  logic [23:0]      addr;
  logic [LEN_W-1:0] rem;
  logic [2:0]       n;
  logic [1:0]       k;
  logic [31:0]      wbuf, rbuf;
  logic             a3, rdir, wdir, prog, fresh;
  logic [PW-1:0]    polls;
  logic [1:0]       err;

  logic             c_ok, c_a3, c_rd, c_wr, c_chunk, c_prog;
  logic [2:0]       c_fix;
  logic [LEN_W-1:0] start_len;
  logic             last_k;

  always_comb begin
    c_ok = 1'b1; c_a3 = 1'b0; c_rd = 1'b0; c_wr = 1'b0;
    c_chunk = 1'b0; c_prog = 1'b0; c_fix = 3'd0;
    case (req_opcode)
      8'h06, 8'h04, 8'hC7: ;
      8'h9F: begin c_rd = 1'b1; c_fix = 3'd3; end
      8'h05: begin c_rd = 1'b1; c_fix = 3'd1; end
      8'h01: begin c_wr = 1'b1; c_fix = 3'd1; end
      8'hAB: begin c_a3 = 1'b1; c_rd = 1'b1; c_fix = 3'd1; end
      8'hD8: c_a3 = 1'b1;
      8'h03, 8'h0B: begin c_a3 = 1'b1; c_rd = 1'b1; c_chunk = 1'b1; end
      8'h02: begin c_a3 = 1'b1; c_wr = 1'b1; c_chunk = 1'b1; c_prog = 1'b1; end
      default: c_ok = 1'b0;
    endcase
  end

  assign start_len = c_chunk ? (c_rd ? req_rlen : req_wlen) : LEN_W'(c_fix);
  assign last_k    = ({1'b0, k} == n - 3'd1);

  assign req_ready  = (st == S_IDLE);
  assign done       = (st == S_DONE);
  assign done_err   = err;
  assign wr_ready   = (st == S_GATHER) || (st == S_DUMMY);
  assign rd_valid   = (st == S_EMIT);
  assign rd_data    = rbuf[{k, 3'b000} +: 8];
  assign frm_valid  = (st == S_WREN) || (st == S_CMD) || (st == S_POLL);
  assign frm_opcode = (st == S_WREN) ? 8'h06 : (st == S_POLL) ? 8'h05 : op;
  assign frm_addr   = addr;
  assign frm_alen   = (st == S_CMD && a3) ? 2'd3 : 2'd0;
  assign frm_wlen   = (st == S_CMD && wdir) ? n : 3'd0;
  assign frm_rlen   = (st == S_CMD && rdir) ? n : (st == S_POLL) ? 3'd1 : 3'd0;
  assign frm_wdata  = wbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; addr <= '0; rem <= '0; n <= '0; k <= '0;
      wbuf <= '0; rbuf <= '0; a3 <= 1'b0; rdir <= 1'b0; wdir <= 1'b0;
      prog <= 1'b0; fresh <= 1'b0; polls <= '0; err <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op    <= (req_opcode == 8'h0B) ? 8'h03 : req_opcode;
          addr  <= req_addr;
          rem   <= start_len;
          a3    <= c_a3; rdir <= c_rd; wdir <= c_wr; prog <= c_prog;
          fresh <= 1'b1;
          err   <= 2'd0;
          if (!c_ok) begin err <= 2'd1; st <= S_DONE; end
          else if (req_wlen != '0 && req_rlen != '0) begin err <= 2'd2; st <= S_DONE; end
          else if (c_chunk && start_len == '0) st <= S_DONE;
          else if (req_opcode == 8'h0B) st <= S_DUMMY;
          else st <= S_NEXT;
        end
        S_DUMMY: if (wr_valid) st <= S_NEXT;
        S_NEXT: begin
          if (rem == '0 && !fresh) st <= S_DONE;
          else begin
            n     <= (rem > LEN_W'(4)) ? 3'd4 : rem[2:0];
            k     <= '0;
            wbuf  <= '0;
            polls <= '0;
            st    <= (wdir && rem != '0) ? S_GATHER : prog ? S_WREN : S_CMD;
          end
        end
        S_GATHER: if (wr_valid) begin
          wbuf[{k, 3'b000} +: 8] <= wr_data;
          k <= k + 2'd1;
          if (last_k) begin k <= '0; st <= prog ? S_WREN : S_CMD; end
        end
        S_WREN:   if (frm_ready) st <= S_WREN_W;
        S_WREN_W: if (eng_done) st <= S_CMD;
        S_CMD:    if (frm_ready) st <= S_CMD_W;
        S_CMD_W: if (eng_done) begin
          rbuf <= eng_rdata;
          k    <= '0;
          if (rdir && n != 3'd0) st <= S_EMIT;
          else if (prog) st <= S_POLL;
          else begin
            addr <= addr + 24'(n); rem <= rem - LEN_W'(n); fresh <= 1'b0; st <= S_NEXT;
          end
        end
        S_EMIT: if (rd_ready) begin
          k <= k + 2'd1;
          if (last_k) begin
            addr <= addr + 24'(n); rem <= rem - LEN_W'(n); fresh <= 1'b0; st <= S_NEXT;
          end
        end
        S_POLL: if (frm_ready) st <= S_POLL_W;
        S_POLL_W: if (eng_done) begin
          if (!eng_rdata[0]) begin
            addr <= addr + 24'(n); rem <= rem - LEN_W'(n); fresh <= 1'b0; st <= S_NEXT;
          end else if (polls == PW'(POLL_MAX - 1)) begin
            err <= 2'd3; st <= S_DONE;
          end else begin
            polls <= polls + 1'b1; st <= S_POLL;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_chunk_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (frm_wlen <= 3'd4 && frm_rlen <= 3'd4));
  p_wren_bare_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_opcode == 8'h06) |-> (frm_alen == 2'd0 && frm_wlen == 3'd0 && frm_rlen == 3'd0));
  p_poll_again_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL_W && eng_done && eng_rdata[0] && polls != PW'(POLL_MAX - 1))
      |=> (frm_valid && frm_opcode == 8'h05 && frm_rlen == 3'd1));
  p_poll_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    polls <= PW'(POLL_MAX - 1));
  p_one_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frm_valid, rd_valid, wr_ready, done}));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  p_frm_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_opcode) && $stable(frm_addr)
      && $stable(frm_wdata) && $stable(frm_wlen) && $stable(frm_rlen)));
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/test_flash_burst_seq.sv
`timescale 1ns/1ps
module test_flash_burst_seq;
  localparam int PM = 4;
  localparam int LW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_opcode = '0;
  logic [23:0] req_addr = '0;
  logic [LW-1:0] req_wlen = '0, req_rlen = '0;
  logic done; logic [1:0] done_err;
  logic wr_valid = 1'b0, wr_ready; logic [7:0] wr_data = '0;
  logic rd_valid, rd_ready = 1'b0; logic [7:0] rd_data;
  logic frm_valid, frm_ready = 1'b0;
  logic [7:0] frm_opcode; logic [23:0] frm_addr; logic [1:0] frm_alen;
  logic [2:0] frm_wlen, frm_rlen; logic [31:0] frm_wdata;
  logic eng_done = 1'b0; logic [31:0] eng_rdata = '0;

  flash_burst_seq #(.LEN_W(LW), .POLL_MAX(PM)) i_flash_burst_seq (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [7:0] wq [64]; int wq_n = 0, wq_i = 0, nwc = 0; bit wr_fire = 0;
  logic [7:0] rx [64]; int nrx = 0; bit rd_pend = 0; logic [7:0] rd_prev;
  logic [7:0] lg_op [64]; logic [23:0] lg_ad [64]; logic [1:0] lg_al [64];
  logic [2:0] lg_wl [64], lg_rl [64]; logic [31:0] lg_wd [64]; int nf = 0;
  int e_st = 0, lat = 0, wip_left = 0, busy_cfg = 0; bit held = 0;
  logic [7:0] h_op; logic [23:0] h_ad; logic [31:0] h_wd;
  logic [7:0] cur_op; logic [23:0] cur_ad; logic [1:0] cur_al;

  logic [7:0] ex_op [64]; logic [23:0] ex_ad [64]; logic [1:0] ex_al [64];
  logic [2:0] ex_wl [64], ex_rl [64]; logic [31:0] ex_wd [64]; int ne;
  logic [7:0] erx [64]; int enrx, ewc; logic [1:0] eerr;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ a[23:16] ^ 8'h5C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (wr_fire) begin wq_i++; nwc++; end
    wr_valid = (wq_i < wq_n) && ($urandom % 4 != 0);
    wr_data  = wq[wq_i % 64];
    wr_fire  = wr_valid && wr_ready;
    if (rd_pend) begin
      chk("R12 rd_valid held", 32'(rd_valid), 32'd1);
      chk("R12 rd_data held", 32'(rd_data), 32'(rd_prev));
    end
    rd_ready = ($urandom % 3 != 0);
    rd_pend  = rd_valid && !rd_ready;
    rd_prev  = rd_data;
    if (rd_valid && rd_ready) begin rx[nrx % 64] = rd_data; nrx++; end
    if (eng_done) eng_done = 1'b0;
    case (e_st)
      0: if (frm_valid) begin
        if (held) begin
          chk("R12 frame opcode held", 32'(frm_opcode), 32'(h_op));
          chk("R12 frame addr held", 32'(frm_addr), 32'(h_ad));
          chk("R12 frame wdata held", frm_wdata, h_wd);
        end
        if ($urandom % 3 == 0) begin
          held = 1; h_op = frm_opcode; h_ad = frm_addr; h_wd = frm_wdata;
        end else begin
          held = 0;
          lg_op[nf % 64] = frm_opcode; lg_ad[nf % 64] = frm_addr; lg_al[nf % 64] = frm_alen;
          lg_wl[nf % 64] = frm_wlen; lg_rl[nf % 64] = frm_rlen; lg_wd[nf % 64] = frm_wdata;
          nf++;
          cur_op = frm_opcode; cur_ad = frm_addr; cur_al = frm_alen;
          frm_ready = 1'b1; e_st = 1;
        end
      end
      1: begin frm_ready = 1'b0; lat = $urandom % 3; e_st = 2; end
      default: if (lat == 0) begin
        if (cur_op == 8'h05) begin
          eng_rdata = (wip_left > 0) ? 32'h41 : 32'h40;
          if (wip_left > 0) wip_left--;
        end else begin
          for (int i = 0; i < 4; i++)
            eng_rdata[8*i +: 8] = pat((cur_al == 2'd3 ? cur_ad : 24'd0) + 24'(i));
          if (cur_op == 8'h02) wip_left = busy_cfg;
        end
        eng_done = 1'b1; e_st = 0;
      end else lat--;
    endcase
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic ex_add(input logic [7:0] o, input logic [1:0] al, input int wl, input int rl,
                        input logic [23:0] a, input logic [31:0] wd);
    ex_op[ne] = o; ex_al[ne] = al; ex_wl[ne] = 3'(wl); ex_rl[ne] = 3'(rl);
    ex_ad[ne] = a; ex_wd[ne] = wd; ne++;
  endtask

  task automatic predict(input logic [7:0] op, input logic [23:0] a, input int wl, input int rl,
                         input int busy);
    ne = 0; enrx = 0; ewc = 0; eerr = 0;
    case (op)
      8'h06, 8'h04, 8'hC7, 8'h9F, 8'h05, 8'h01, 8'hAB, 8'hD8, 8'h03, 8'h0B, 8'h02: ;
      default: begin eerr = 1; return; end
    endcase
    if (wl != 0 && rl != 0) begin eerr = 2; return; end
    case (op)
      8'h06, 8'h04, 8'hC7: ex_add(op, 0, 0, 0, a, 0);
      8'h9F: begin ex_add(op, 0, 0, 3, a, 0); for (int i = 0; i < 3; i++) erx[enrx++] = pat(24'(i)); end
      8'h05: begin ex_add(op, 0, 0, 1, a, 0); erx[enrx++] = 8'h40; end
      8'h01: begin ex_add(op, 0, 1, 0, a, {24'd0, wq[0]}); ewc = 1; end
      8'hAB: begin ex_add(op, 3, 0, 1, a, 0); erx[enrx++] = pat(a); end
      8'hD8: ex_add(op, 3, 0, 0, a, 0);
      8'h03, 8'h0B: begin
        if (op == 8'h0B && rl > 0) ewc = 1;
        for (int off = 0; off < rl; off += 4) begin
          int c = (rl - off > 4) ? 4 : rl - off;
          ex_add(8'h03, 3, 0, c, a + 24'(off), 0);
          for (int i = 0; i < c; i++) erx[enrx++] = pat(a + 24'(off + i));
        end
      end
      default: begin
        for (int off = 0; off < wl; off += 4) begin
          int c = (wl - off > 4) ? 4 : wl - off;
          logic [31:0] wd = 0;
          for (int i = 0; i < c; i++) wd[8*i +: 8] = wq[ewc + i];
          ewc += c;
          ex_add(8'h06, 0, 0, 0, a, 0);
          ex_add(8'h02, 3, c, 0, a + 24'(off), wd);
          if (busy + 1 > PM) begin
            for (int p = 0; p < PM; p++) ex_add(8'h05, 0, 0, 1, a, 0);
            eerr = 3; return;
          end
          for (int p = 0; p <= busy; p++) ex_add(8'h05, 0, 0, 1, a, 0);
        end
      end
    endcase
  endtask

  task automatic run(input logic [7:0] op, input logic [23:0] a, input int wl, input int rl,
                     input int busy, input string tag);
    int t = 0;
    logic [1:0] got_err;
    @(negedge clk);
    nf = 0; nrx = 0; nwc = 0; wq_i = 0; wip_left = 0; busy_cfg = busy;
    for (int i = 0; i < 16; i++) wq[i] = 8'($urandom);
    wq_n = 16;
    req_opcode = op; req_addr = a; req_wlen = LW'(wl); req_rlen = LW'(rl); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    got_err = done_err;
    chk({tag, " R10 done seen"}, 32'(done), 32'd1);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, 32'(done), 32'd0);
    chk({tag, " R10 ready after done"}, 32'(req_ready), 32'd1);
    wq_n = 0;
    predict(op, a, wl, rl, busy);
    chk({tag, " result code"}, 32'(got_err), 32'(eerr));
    chk({tag, " frame count"}, nf, ne);
    for (int i = 0; i < ne && i < nf; i++) begin
      chk({tag, " frame opcode"}, 32'(lg_op[i]), 32'(ex_op[i]));
      chk({tag, " frame alen"}, 32'(lg_al[i]), 32'(ex_al[i]));
      chk({tag, " frame wlen"}, 32'(lg_wl[i]), 32'(ex_wl[i]));
      chk({tag, " frame rlen"}, 32'(lg_rl[i]), 32'(ex_rl[i]));
      if (ex_al[i] == 2'd3) chk({tag, " frame addr"}, 32'(lg_ad[i]), 32'(ex_ad[i]));
      if (ex_wl[i] != 0) chk({tag, " frame wdata"}, lg_wd[i], ex_wd[i]);
    end
    chk({tag, " write bytes taken"}, nwc, ewc);
    chk({tag, " read byte count"}, nrx, enrx);
    for (int i = 0; i < enrx && i < nrx; i++) chk({tag, " read byte"}, 32'(rx[i]), 32'(erx[i]));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 req_ready", 32'(req_ready), 32'd1);
    chk("R11 frm_valid", 32'(frm_valid), 32'd0);
    chk("R11 rd_valid", 32'(rd_valid), 32'd0);
    chk("R11 wr_ready", 32'(wr_ready), 32'd0);
    chk("R11 done", 32'(done), 32'd0);

    run(8'h03, 24'hFFFFFE, 0, 10, 0, "R1 R8 wrap read");
    run(8'h02, 24'h001000, 6, 0, 2, "R2 R3 R9 program");
    run(8'h02, 24'h000200, 3, 0, 9, "R4 poll timeout");
    run(8'h06, 24'h000010, 0, 0, 0, "R5 0x06");
    run(8'h04, 24'h000010, 0, 0, 0, "R5 0x04");
    run(8'hC7, 24'h000010, 0, 0, 0, "R5 0xC7");
    run(8'h9F, 24'h000010, 0, 0, 0, "R5 0x9F");
    run(8'h05, 24'h000010, 0, 0, 0, "R5 0x05");
    run(8'h01, 24'h000010, 0, 0, 0, "R5 0x01");
    run(8'hAB, 24'h0A0B0C, 0, 0, 0, "R5 0xAB");
    run(8'hD8, 24'h0A0000, 0, 0, 0, "R5 0xD8");
    run(8'h0B, 24'h123456, 0, 5, 0, "R6 fast read");
    run(8'h42, 24'h000000, 0, 4, 0, "R7 unknown");
    run(8'h03, 24'h000100, 2, 3, 0, "R7 mixed");
    run(8'h03, 24'h000100, 0, 0, 0, "R10 zero read");
    run(8'h02, 24'h000100, 0, 0, 0, "R10 zero program");

    for (int it = 0; it < 24; it++) begin
      int sel = $urandom % 3;
      int len = 1 + ($urandom % 11);
      logic [23:0] a = 24'($urandom);
      int busy = $urandom % 3;
      if (sel == 0) run(8'h03, a, 0, len, 0, "R1 R8 random read");
      else if (sel == 1) run(8'h0B, a, 0, len, 0, "R6 random fast read");
      else run(8'h02, a, len, 0, busy, "R1 R9 random program");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule